// File: doc/BRIEF.md
# MCTP-over-SMBus Response Packet Transmitter

This block sends MCTP response packets as the controller side of an SMBus/I2C link, one byte at a time. It leaves bus arbitration, bit timing and the content of replies to other blocks. A single start pulse latches the requester's bus address, its endpoint ID and its tag. From that point the block produces one or more packets. Each packet is followed by a stop request. The byte channel toward the bus PHY uses a valid/ready handshake, and the stop request uses the same ready line.

There are two kinds of traffic. A control reply already sits in a payload store, and its length is given with the start pulse. It goes out as exactly one packet. Any other reply is pulled from a message source one packet at a time. The block asks for at most one MTU of payload, and the source answers with a byte count and the start and end flags for that packet. When the source answers zero, the transfer is over and the block goes back to idle.

The block does not hold the packet bytes in a buffer. Header fields are selected by send position. Payload bytes are read through an index/data port, and the PEC is built up as each byte is accepted.

Top module: `mctp_pkt_tx`

## Requirements
- R1: After reset, busy, bus_send, bus_stop and seg_req are all low. No bytes leave until a start pulse arrives.
- R2: A start pulse while idle makes busy high from the next cycle. Busy stays high until the final stop is accepted. A start pulse while busy has no effect on the bytes sent, and no second transfer follows from it.
- R3: Packet bytes leave in position order, one per cycle in which bus_send and bus_rdy are both high. While bus_rdy is low, bus_send and bus_byte hold their values.
- R4: Each packet has a fixed layout. Byte 0 is the destination address shifted left with bit 0 clear. Byte 1 is 0x0F. Byte 2 is the byte count. Byte 3 is own_addr shifted left with bit 0 set. Byte 4 is 0x01. Byte 5 is the destination EID. Byte 6 is own_eid. Byte 7 holds the flags: bit 7 is start, bit 6 is end, bits 5:4 are the sequence number, bit 3 is 0 and bits 2:0 are the tag. The payload follows, and the PEC byte comes last.
- R5: The byte count equals the payload length plus 5, which is the packet length minus 3 minus the PEC byte. The PEC is a CRC-8 with polynomial x^8+x^2+x+1 and initial value 0, taken over every earlier byte of the packet, the address byte included.
- R6: A control reply (req_ctl=1) of N bytes, with N taken from req_ctl_len and clamped to MTU, goes out as one packet. That packet has the start and end flags set, sequence 0, and payload bytes read at pay_idx 0..N-1. If N is 0, no bytes are sent and the block returns to idle.
- R7: For non-control traffic the block raises seg_req for one cycle before each packet. It then takes seg_cnt, clamped to MTU, together with seg_som and seg_eom on seg_ack.
- R8: The sequence number is 0 for the first packet after start and for any packet with seg_som set. Otherwise it is the previous packet's sequence number plus 1, modulo 4.
- R9: A stop request follows every packet. When it is accepted, the packet length is cleared and the next packet is prepared. A source answer of zero bytes ends the transfer with no further bytes or stop.
- R10: Replies are addressed to req_saddr and req_seid and carry req_tag. All three are latched at start, so later changes on those inputs have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a reply transfer |
| req_ctl | input | 1 | Reply is a pre-built control reply |
| req_ctl_len | input | CW | Control reply payload length |
| req_saddr | input | 7 | Requester bus address |
| req_seid | input | 8 | Requester endpoint ID |
| req_tag | input | 3 | Requester tag bits |
| own_addr | input | 7 | This endpoint's bus address |
| own_eid | input | 8 | This endpoint's endpoint ID |
| seg_req | output | 1 | Request next payload segment from the source |
| seg_ack | input | 1 | Source answer valid |
| seg_cnt | input | CW | Source payload byte count |
| seg_som | input | 1 | Source start-of-message flag |
| seg_eom | input | 1 | Source end-of-message flag |
| pay_idx | output | LW | Payload byte index |
| pay_byte | input | 8 | Payload byte at pay_idx |
| bus_send | output | 1 | Byte send request |
| bus_byte | output | 8 | Byte to send |
| bus_stop | output | 1 | End-of-transfer request |
| bus_rdy | input | 1 | Bus accepts the current byte or stop |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions rely on the environment behaving in a few ways. The source raises seg_ack only in answer to a seg_req, and once per request. pay_byte depends only on pay_idx while a packet is being sent. bus_rdy may take any value in any cycle. The bench source keeps to this: it watches for each request, answers a fixed two cycles later, and changes its payload salt only together with its answer. A pseudo-random ready pattern stretches bytes and stops by arbitrary amounts.

// File: rtl/mctp_pkt_tx.sv
module mctp_pkt_tx #(
  parameter int MTU = 64,
  localparam int CW = $clog2(MTU + 1),
  localparam int LW = $clog2(MTU + 10)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_ctl,
  input  logic [CW-1:0] req_ctl_len,
  input  logic [6:0]    req_saddr,
  input  logic [7:0]    req_seid,
  input  logic [2:0]    req_tag,
  input  logic [6:0]    own_addr,
  input  logic [7:0]    own_eid,
  output logic          seg_req,
  input  logic          seg_ack,
  input  logic [CW-1:0] seg_cnt,
  input  logic          seg_som,
  input  logic          seg_eom,
  output logic [LW-1:0] pay_idx,
  input  logic [7:0]    pay_byte,
  output logic          bus_send,
  output logic [7:0]    bus_byte,
  output logic          bus_stop,
  input  logic          bus_rdy,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_WAIT, S_SEND, S_STOP} st_t;

  st_t           st;
  logic          is_ctl, first, som, eom;
  logic [CW-1:0] ctl_len;
  logic [6:0]    daddr;
  logic [7:0]    deid;
  logic [2:0]    tag;
  logic [1:0]    seq;
  logic [LW-1:0] len, pos;
  logic [7:0]    pec;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  wire [CW-1:0] seg_clamp = (seg_cnt > CW'(MTU)) ? CW'(MTU) : seg_cnt;
  wire [CW-1:0] ctl_clamp = (req_ctl_len > CW'(MTU)) ? CW'(MTU) : req_ctl_len;

  assign busy     = (st != S_IDLE);
  assign seg_req  = (st == S_PREP) && !is_ctl;
  assign bus_send = (st == S_SEND) && (pos < len);
  assign bus_stop = (st == S_STOP);
  assign pay_idx  = pos - LW'(8);

  always_comb begin
    case (pos)
      LW'(0):  bus_byte = {daddr, 1'b0};
      LW'(1):  bus_byte = 8'h0F;
      LW'(2):  bus_byte = 8'(len - LW'(4));
      LW'(3):  bus_byte = {own_addr, 1'b1};
      LW'(4):  bus_byte = 8'h01;
      LW'(5):  bus_byte = deid;
      LW'(6):  bus_byte = own_eid;
      LW'(7):  bus_byte = {som, eom, seq, 1'b0, tag};
      default: bus_byte = (pos == len - LW'(1)) ? pec : pay_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_ctl  <= 1'b0;
      first   <= 1'b0;
      som     <= 1'b0;
      eom     <= 1'b0;
      ctl_len <= '0;
      daddr   <= '0;
      deid    <= '0;
      tag     <= '0;
      seq     <= '0;
      len     <= '0;
      pos     <= '0;
      pec     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          is_ctl  <= req_ctl;
          ctl_len <= ctl_clamp;
          daddr   <= req_saddr;
          deid    <= req_seid;
          tag     <= req_tag;
          first   <= 1'b1;
          st      <= S_PREP;
        end
        S_PREP: begin
          pos <= '0;
          pec <= '0;
          if (!is_ctl) st <= S_WAIT;
          else if (ctl_len == '0) begin
            len <= '0;
            st  <= S_IDLE;
          end else begin
            len <= LW'(ctl_len) + LW'(9);
            som <= 1'b1;
            eom <= 1'b1;
            seq <= 2'd0;
            st  <= S_SEND;
          end
        end
        S_WAIT: if (seg_ack) begin
          if (seg_clamp == '0) begin
            len <= '0;
            st  <= S_IDLE;
          end else begin
            len   <= LW'(seg_clamp) + LW'(9);
            som   <= seg_som;
            eom   <= seg_eom;
            seq   <= (seg_som || first) ? 2'd0 : seq + 2'd1;
            first <= 1'b0;
            st    <= S_SEND;
          end
        end
        S_SEND: begin
          if (pos < len) begin
            if (bus_rdy) begin
              pec <= crc8(pec, bus_byte);
              pos <= pos + LW'(1);
            end
          end else st <= S_STOP;
        end
        S_STOP: if (bus_rdy) begin
          len <= '0;
          st  <= is_ctl ? S_IDLE : S_PREP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mctp_pkt_tx_chk.sv
module mctp_pkt_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       seg_req,
  input logic       bus_send,
  input logic [7:0] bus_byte,
  input logic       bus_stop,
  input logic       bus_rdy
);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_send && !bus_stop && !seg_req);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_send_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_send |=> busy);

  assert_byte_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_send && !bus_rdy |=> bus_send && $stable(bus_byte));

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req |=> !seg_req);

  assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_send && bus_stop));

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop && !bus_rdy |=> bus_stop);

  assert_stop_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop && bus_rdy |=> !bus_send && !bus_stop);

endmodule

bind mctp_pkt_tx mctp_pkt_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .seg_req(seg_req),
  .bus_send(bus_send), .bus_byte(bus_byte), .bus_stop(bus_stop), .bus_rdy(bus_rdy)
);

// File: tb/sim_mctp_pkt_tx.sv
`timescale 1ns/1ps
module sim_mctp_pkt_tx;
  localparam int MTU = 64;
  localparam int CW = $clog2(MTU + 1);
  localparam int LW = $clog2(MTU + 10);

  logic clk = 0, rst_n = 0, start = 0, req_ctl = 0;
  logic [CW-1:0] req_ctl_len = '0, seg_cnt = '0;
  logic [6:0] req_saddr = '0, own_addr = 7'h1D;
  logic [7:0] req_seid = '0, own_eid = 8'h09, pay_byte, salt = '0;
  logic [2:0] req_tag = '0;
  logic seg_req, seg_ack = 0, seg_som = 0, seg_eom = 0;
  logic [LW-1:0] pay_idx;
  logic bus_send, bus_stop, bus_rdy = 0, busy;
  logic [7:0] bus_byte;

  int total = 0, bad = 0;
  logic [8:0] exp_q[$];
  string exp_r[$];
  int src_cnt[$], src_flag[$], src_salt[$];
  logic [7:0] e_pec;
  logic [6:0] e_addr;
  logic [7:0] e_eid;
  logic [2:0] e_tag;

  always #2 clk = ~clk;

  assign pay_byte = 8'(pay_idx * 13) + salt;

  mctp_pkt_tx #(.MTU(MTU)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ctl(req_ctl), .req_ctl_len(req_ctl_len),
    .req_saddr(req_saddr), .req_seid(req_seid), .req_tag(req_tag), .own_addr(own_addr),
    .own_eid(own_eid), .seg_req(seg_req), .seg_ack(seg_ack), .seg_cnt(seg_cnt),
    .seg_som(seg_som), .seg_eom(seg_eom), .pay_idx(pay_idx), .pay_byte(pay_byte),
    .bus_send(bus_send), .bus_byte(bus_byte), .bus_stop(bus_stop), .bus_rdy(bus_rdy),
    .busy(busy));

  task automatic check(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic put(input logic [7:0] b, input string r);
    exp_q.push_back({1'b0, b});
    exp_r.push_back(r);
    e_pec = crc8(e_pec, b);
  endtask

  task automatic push_pkt(input bit som, input bit eom, input logic [1:0] sq,
                          input int n, input logic [7:0] sl, input string r);
    e_pec = 8'h00;
    put({e_addr, 1'b0}, {r, " R4 R10 dest"});
    put(8'h0F, {r, " R4 cmd"});
    put(8'(n + 5), {r, " R5 count"});
    put({own_addr, 1'b1}, {r, " R4 src"});
    put(8'h01, {r, " R4 ver"});
    put(e_eid, {r, " R10 deid"});
    put(own_eid, {r, " R4 seid"});
    put({som, eom, sq, 1'b0, e_tag}, {r, " R8 R10 flags"});
    for (int i = 0; i < n; i++) put(8'(i * 13) + sl, {r, " R3 payload"});
    exp_q.push_back({1'b0, e_pec});
    exp_r.push_back({r, " R5 pec"});
    exp_q.push_back(9'h100);
    exp_r.push_back({r, " R9 stop"});
  endtask

  task automatic take(input logic [8:0] v);
    if (exp_q.size() == 0) check(0, "R2 R9 unexpected output", v, 'h1FF);
    else begin
      logic [8:0] e = exp_q.pop_front();
      string r = exp_r.pop_front();
      check(v == e, r, v, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_send && bus_rdy) take({1'b0, bus_byte});
    if (bus_stop && bus_rdy) take(9'h100);
  end

  initial begin : rdy_gen
    logic [7:0] lf = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      bus_rdy = lf[0] | lf[2];
    end
  end

  initial begin : source
    forever begin
      @(negedge clk);
      if (seg_req) begin
        @(posedge clk); @(posedge clk); #1;
        seg_ack = 1;
        if (src_cnt.size() != 0) begin
          seg_cnt = CW'(src_cnt.pop_front());
          {seg_som, seg_eom} = 2'(src_flag.pop_front());
          salt = 8'(src_salt.pop_front());
        end else begin
          seg_cnt = '0;
          {seg_som, seg_eom} = 2'b00;
        end
        @(posedge clk); #1;
        seg_ack = 0;
      end
    end
  end

  task automatic kick(input bit ctl, input int cl, input logic [6:0] a,
                      input logic [7:0] e, input logic [2:0] t);
    @(posedge clk); #1;
    start = 1; req_ctl = ctl; req_ctl_len = CW'(cl);
    req_saddr = a; req_seid = e; req_tag = t;
    @(posedge clk); #1;
    start = 0;
    req_saddr = ~a; req_seid = ~e; req_tag = ~t;
  endtask

  task automatic finish_msg(input string r);
    do @(negedge clk); while (busy);
    check(exp_q.size() == 0, {r, " all bytes sent"}, exp_q.size(), 0);
    check(src_cnt.size() == 0, {r, " source drained"}, src_cnt.size(), 0);
  endtask

  task automatic seg(input int n, input bit s, input bit e, input int sl);
    src_cnt.push_back(n);
    src_flag.push_back({s, e});
    src_salt.push_back(sl);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !bus_send && !bus_stop && !seg_req, "R1 reset outputs",
          {busy, bus_send, bus_stop, seg_req}, 0);
    rst_n = 1;

    // R6 control reply, one packet with start and end flags
    e_addr = 7'h12; e_eid = 8'h21; e_tag = 3'd5; salt = 8'h40;
    push_pkt(1, 1, 2'd0, 4, 8'h40, "R6 ctl");
    kick(1, 4, e_addr, e_eid, e_tag);
    #1; check(busy, "R2 busy after start", busy, 1);
    finish_msg("R6 ctl");

    // R7 R8 multi-packet with max-size middle packet
    e_addr = 7'h33; e_eid = 8'h44; e_tag = 3'd2;
    seg(10, 1, 0, 8'h01); seg(MTU, 0, 0, 8'h02); seg(5, 0, 1, 8'h03);
    push_pkt(1, 0, 2'd0, 10, 8'h01, "R7 m0");
    push_pkt(0, 0, 2'd1, MTU, 8'h02, "R7 m1");
    push_pkt(0, 1, 2'd2, 5, 8'h03, "R7 m2");
    kick(0, 0, e_addr, e_eid, e_tag);
    finish_msg("R7 multi");

    // R7 clamp to MTU
    seg(MTU + 3, 1, 1, 8'h11);
    push_pkt(1, 1, 2'd0, MTU, 8'h11, "R7 clamp");
    kick(0, 0, e_addr, e_eid, e_tag);
    finish_msg("R7 clamp");

    // R8 sequence wraps modulo 4
    e_tag = 3'd7;
    for (int i = 0; i < 6; i++) begin
      seg(1 + i, i == 0, i == 5, 8'h20 + i);
      push_pkt(i == 0, i == 5, 2'(i), 1 + i, 8'(8'h20 + i), "R8 wrap");
    end
    kick(0, 0, e_addr, e_eid, e_tag);
    finish_msg("R8 wrap");

    // R8 start flag mid-stream restarts sequence
    seg(3, 1, 0, 8'h50); seg(3, 0, 1, 8'h51); seg(3, 1, 1, 8'h52);
    push_pkt(1, 0, 2'd0, 3, 8'h50, "R8 restart");
    push_pkt(0, 1, 2'd1, 3, 8'h51, "R8 restart");
    push_pkt(1, 1, 2'd0, 3, 8'h52, "R8 restart");
    kick(0, 0, e_addr, e_eid, e_tag);
    finish_msg("R8 restart");

    // R2 start while busy ignored
    e_addr = 7'h05; e_eid = 8'h66; e_tag = 3'd1;
    seg(20, 1, 1, 8'h70);
    push_pkt(1, 1, 2'd0, 20, 8'h70, "R2 ignore");
    kick(0, 0, e_addr, e_eid, e_tag);
    repeat (15) @(posedge clk);
    kick(1, 3, 7'h7F, 8'hEE, 3'd6);
    #1; check(busy, "R2 busy held", busy, 1);
    finish_msg("R2 ignore");
    repeat (20) @(negedge clk);
    check(!busy, "R2 no second transfer", busy, 0);

    // R6 zero-length control reply
    kick(1, 0, 7'h01, 8'h02, 3'd0);
    repeat (6) @(negedge clk);
    check(!busy, "R6 zero ctl idle", busy, 0);
    check(exp_q.size() == 0, "R6 zero ctl no bytes", exp_q.size(), 0);

    // R9 source returns zero at once
    kick(0, 0, 7'h01, 8'h02, 3'd0);
    repeat (10) @(negedge clk);
    check(!busy, "R9 zero source idle", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule